// File: doc/BRIEF.md
# Command-Gated Reconfigurable Scan Chain

This block is a serial test data path that sits behind a standard test access port. A 16-bit command register always sits nearest the serial input. Behind it, an image of the on-chip memory can be spliced into the path or removed from it. A small mode controller decides which, based on the command word that is latched when the update strobe fires. The path is therefore 16 bits long in its default configuration. It grows to 16 plus the memory width whenever the memory image is attached.

Programming the memory takes two steps. First an arm command attaches the image. The next scan then carries both the new image and a commit command. The commit copies the shifted image into the backing store one word per clock through a narrow write port, and a busy flag is held for the duration of the copy. A verify command attaches the image read-only, so stored contents can be read out while the bits shifted in are thrown away.

The tap state machine is not part of this block. It supplies the capture, shift, update and test-logic-reset strobes, which are sampled on the rising edge of the test clock.

Top module: `cmd_gated_scan_chain`

## Requirements
- R1: An asynchronous low `trst_n` puts the block in command-only mode, clears the stored image and the chain registers to zero, and drives `tdo_o` low.
- R2: In command-only mode the path from `tdi_o`'s input to `tdo_o` is exactly 16 bits long, so a bit shifted in reappears at the output 16 shifts later.
- R3: Bits travel least significant first. On capture, the command register loads the status word. The status word is 0x3C9 in bits [15:4], 0 in bit 3, the busy flag in bit 2, and the mode code in bits [1:0]: 0 for command-only, 1 for write-enabled, 2 for verify. The arm code 0xA5E1, latched at update in command-only or verify mode, selects write-enabled mode. From the next capture on, the memory image is loaded with the stored contents and placed behind the command register. Its bit 0 sits nearest `tdo_o`, giving a chain of 16 plus the memory width.
- R4: The commit code 0xA5D2, latched in write-enabled mode, returns the chain to command-only. It also writes the shifted image into the store, one word per clock over memory-width/word-width cycles. During this copy `mem_we_o` is high, and `mem_addr_o` counts up from 0 with `mem_wdata_o` carrying image bits [addr*W +: W].
- R5: Any code other than the commit code, latched in write-enabled mode, aborts the sequence. The chain returns to command-only and no write takes place.
- R6: The verify code 0xA5C3 attaches the image read-only. Captured contents shift out unchanged, and no scan in verify mode alters the store. In verify mode the arm code goes to write-enabled, the verify code stays in verify, and any other code returns to command-only.
- R7: In command-only mode, every code except arm and verify is ignored. The mode does not change and nothing is written.
- R8: While a commit is in progress, every update is ignored. Status captured in that window shows the busy bit set.
- R9: A test-logic-reset strobe returns the controller to command-only mode at the next clock.
- R10: `tdo_o` changes only on the falling edge of `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tlr_i | input | 1 | Test-logic-reset state strobe |
| capture_i | input | 1 | Capture strobe for the data register path |
| shift_i | input | 1 | Shift strobe, one bit per rising edge |
| update_i | input | 1 | Update strobe, latches the command |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, falling-edge timed |
| mem_we_o | output | 1 | Store write enable during a commit |
| mem_addr_o | output | ADDR_BITS (5) | Word address of the current write |
| mem_wdata_o | output | WORD_BITS (32) | Word being written |

## Verification
A mode change latched at an update edge only shows at the next capture. The bench therefore reads the status word from the capture that follows, not from the update scan. After a capture or shift edge, the bit becomes visible on `tdo_o` at the following falling edge. The bench samples it half a nanosecond after that falling edge and also confirms it has not moved just after the rising edge. A commit produces its first write on the edge after the update and its last write memory-width/word-width edges later. The bench records write-port activity at falling edges, waits past that window before comparing the rebuilt image and write count, and places an update inside the window to show that updates are ignored while busy.

// File: rtl/cgsc_pkg.sv
package cgsc_pkg;
   typedef enum logic [1:0] {
      CH_CMD    = 2'd0,
      CH_WREN   = 2'd1,
      CH_VERIFY = 2'd2
   } chain_mode_e;

   localparam logic [15:0] OP_ARM    = 16'hA5E1;
   localparam logic [15:0] OP_COMMIT = 16'hA5D2;
   localparam logic [15:0] OP_CHECK  = 16'hA5C3;
   localparam logic [11:0] STATUS_SIG = 12'h3C9;
endpackage

// File: rtl/cgsc_mode_ctrl.sv
module cgsc_mode_ctrl
   import cgsc_pkg::*;
#(
   parameter int CMD_BITS = 16
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic                tlr_i,
   input  logic                update_i,
   input  logic                busy_i,
   input  logic [CMD_BITS-1:0] cmd_i,
   output chain_mode_e         mode_o,
   output logic                commit_o
);
   if (CMD_BITS != 16) begin : g_bad_cmd
      $error("cgsc_mode_ctrl: CMD_BITS must be 16");
   end

   chain_mode_e mode_q, mode_d;
   logic        take;

   assign take     = update_i && !busy_i && !tlr_i;
   assign commit_o = take && (mode_q == CH_WREN) && (cmd_i == OP_COMMIT);
   assign mode_o   = mode_q;

   always_comb begin
      mode_d = mode_q;
      if (tlr_i) begin
         mode_d = CH_CMD;
      end else if (take) begin
         case (mode_q)
            CH_CMD: begin
               if (cmd_i == OP_ARM)        mode_d = CH_WREN;
               else if (cmd_i == OP_CHECK) mode_d = CH_VERIFY;
            end
            CH_VERIFY: begin
               if (cmd_i == OP_ARM)        mode_d = CH_WREN;
               else if (cmd_i == OP_CHECK) mode_d = CH_VERIFY;
               else                        mode_d = CH_CMD;
            end
            default: mode_d = CH_CMD;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) mode_q <= CH_CMD;
      else         mode_q <= mode_d;
   end

   p_tlr_clear_r9: assert property (@(posedge tck) disable iff (!trst_n)
      tlr_i |=> (mode_q == CH_CMD));

   p_busy_freeze_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (busy_i && !tlr_i) |=> $stable(mode_q));

   p_abort_r5: assert property (@(posedge tck) disable iff (!trst_n)
      (update_i && !busy_i && !tlr_i && mode_q == CH_WREN && cmd_i != OP_COMMIT)
      |=> (mode_q == CH_CMD));

   p_arm_r3: assert property (@(posedge tck) disable iff (!trst_n)
      (update_i && !busy_i && !tlr_i && mode_q != CH_WREN && cmd_i == OP_ARM)
      |=> (mode_q == CH_WREN));
endmodule

// File: rtl/cgsc_commit.sv
module cgsc_commit #(
   parameter  int MEM_BITS  = 1024,
   parameter  int WORD_BITS = 32,
   localparam int NWORDS    = MEM_BITS / WORD_BITS,
   localparam int IDXW      = $clog2(NWORDS)
) (
   input  logic                 tck,
   input  logic                 trst_n,
   input  logic                 start_i,
   input  logic [MEM_BITS-1:0]  image_i,
   output logic                 busy_o,
   output logic [MEM_BITS-1:0]  mem_q_o,
   output logic                 wr_en_o,
   output logic [IDXW-1:0]      wr_addr_o,
   output logic [WORD_BITS-1:0] wr_data_o
);
   if (MEM_BITS % WORD_BITS != 0) begin : g_bad_split
      $error("cgsc_commit: MEM_BITS must be a multiple of WORD_BITS");
   end
   if (NWORDS < 2 || (1 << IDXW) != NWORDS) begin : g_bad_words
      $error("cgsc_commit: word count must be a power of two of at least 2");
   end

   localparam logic [IDXW-1:0] LAST = IDXW'(NWORDS - 1);

   logic                 busy_q;
   logic [IDXW-1:0]      idx_q;
   logic [WORD_BITS-1:0] seg_words [NWORDS];

   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      logic [WORD_BITS-1:0] word_q;
      assign seg_words[g] = image_i[g*WORD_BITS +: WORD_BITS];
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)                                word_q <= '0;
         else if (busy_q && idx_q == IDXW'(g))       word_q <= seg_words[g];
      end
      assign mem_q_o[g*WORD_BITS +: WORD_BITS] = word_q;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (idx_q == LAST) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end else if (start_i) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end
   end

   assign busy_o    = busy_q;
   assign wr_en_o   = busy_q;
   assign wr_addr_o = idx_q;
   assign wr_data_o = seg_words[idx_q];

   p_store_hold_r6: assert property (@(posedge tck) disable iff (!trst_n)
      !busy_q |=> $stable(mem_q_o));

   p_commit_len_r4: assert property (@(posedge tck) disable iff (!trst_n)
      $fell(busy_q) |-> ($past(idx_q) == LAST));

   p_start_idle_r8: assert property (@(posedge tck) disable iff (!trst_n)
      !(busy_q && start_i));
endmodule

// File: rtl/cmd_gated_scan_chain.sv
module cmd_gated_scan_chain
   import cgsc_pkg::*;
#(
   parameter  int CMD_BITS  = 16,
   parameter  int MEM_BITS  = 1024,
   parameter  int WORD_BITS = 32,
   localparam int ADDR_BITS = $clog2(MEM_BITS / WORD_BITS)
) (
   input  logic                 tck,
   input  logic                 trst_n,
   input  logic                 tlr_i,
   input  logic                 capture_i,
   input  logic                 shift_i,
   input  logic                 update_i,
   input  logic                 tdi_i,
   output logic                 tdo_o,
   output logic                 mem_we_o,
   output logic [ADDR_BITS-1:0] mem_addr_o,
   output logic [WORD_BITS-1:0] mem_wdata_o
);
   if (CMD_BITS != 16) begin : g_bad_cmd
      $error("cmd_gated_scan_chain: CMD_BITS must be 16");
   end

   chain_mode_e         mode;
   logic                commit;
   logic                busy;
   logic                attached;
   logic [CMD_BITS-1:0] cmd_sr;
   logic [MEM_BITS-1:0] seg_sr;
   logic [MEM_BITS-1:0] mem_q;
   logic [CMD_BITS-1:0] status;

   assign attached = (mode != CH_CMD);
   assign status   = {STATUS_SIG, 1'b0, busy, mode};

   cgsc_mode_ctrl #(.CMD_BITS(CMD_BITS)) ctrl_i (
      .tck      (tck),
      .trst_n   (trst_n),
      .tlr_i    (tlr_i),
      .update_i (update_i),
      .busy_i   (busy),
      .cmd_i    (cmd_sr),
      .mode_o   (mode),
      .commit_o (commit)
   );

   cgsc_commit #(.MEM_BITS(MEM_BITS), .WORD_BITS(WORD_BITS)) commit_i (
      .tck       (tck),
      .trst_n    (trst_n),
      .start_i   (commit),
      .image_i   (seg_sr),
      .busy_o    (busy),
      .mem_q_o   (mem_q),
      .wr_en_o   (mem_we_o),
      .wr_addr_o (mem_addr_o),
      .wr_data_o (mem_wdata_o)
   );

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         cmd_sr <= '0;
      end else if (capture_i) begin
         cmd_sr <= status;
      end else if (shift_i) begin
         cmd_sr <= {tdi_i, cmd_sr[CMD_BITS-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         seg_sr <= '0;
      end else if (attached) begin
         if (capture_i)    seg_sr <= mem_q;
         else if (shift_i) seg_sr <= {cmd_sr[0], seg_sr[MEM_BITS-1:1]};
      end
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) tdo_o <= 1'b0;
      else         tdo_o <= attached ? seg_sr[0] : cmd_sr[0];
   end

   p_seg_frozen_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == CH_CMD) |=> $stable(seg_sr));

   p_write_needs_commit_r4: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(mem_we_o) |-> $past(update_i));
endmodule

// File: tb/cmd_gated_scan_chain_tb_top.sv
`timescale 1ns/100ps
module cmd_gated_scan_chain_tb_top;
   localparam int MB = 64;
   localparam int WB = 2;
   localparam int NW = MB / WB;
   localparam int L  = MB + 16;
   localparam logic [15:0] ARM = 16'hA5E1, COMMIT = 16'hA5D2, CHECK = 16'hA5C3;

   logic tck = 0, trst_n = 0, tlr = 0, cap = 0, sh = 0, upd = 0, tdi = 0;
   logic tdo, we;
   logic [4:0] addr;
   logic [WB-1:0] wdata;

   cmd_gated_scan_chain #(.CMD_BITS(16), .MEM_BITS(MB), .WORD_BITS(WB)) dut_i (
      .tck(tck), .trst_n(trst_n), .tlr_i(tlr), .capture_i(cap), .shift_i(sh),
      .update_i(upd), .tdi_i(tdi), .tdo_o(tdo), .mem_we_o(we),
      .mem_addr_o(addr), .mem_wdata_o(wdata));

   always #2 tck = ~tck;

   int nchk = 0, nfail = 0, we_cnt = 0, wexp = 0;
   bit addr_bad = 0, done = 0, edge_ok;
   logic [MB-1:0] img = '0;
   logic [L-1:0]  so;

   always @(negedge tck) begin
      if (trst_n && we) begin
         if (int'(addr) != wexp) addr_bad = 1;
         img[int'(addr)*WB +: WB] = wdata;
         wexp = (wexp + 1) % NW;
         we_cnt++;
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [L-1:0] act, input logic [L-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] st(input logic [1:0] m, input bit b);
      return {12'h3C9, 1'b0, b, m};
   endfunction

   function automatic logic [MB-1:0] pat_of(input int p);
      logic [31:0] a, b;
      a = (32'(p) * 32'h9E3779B9) ^ 32'h13572468;
      b = ~(32'(p + 1) * 32'h85EBCA6B);
      return {a, b};
   endfunction

   task automatic scan(input bit do_cap, input int len, input logic [L-1:0] din, input bit do_upd);
      edge_ok = 1;
      so = '0;
      @(posedge tck); #1 cap = do_cap; sh = 0; upd = 0;
      for (int k = 0; k < len; k++) begin
         @(posedge tck);
         #0.5 if (k > 0 && tdo !== so[k-1]) edge_ok = 0;
         #0.5 cap = 0; sh = 1; tdi = din[k];
         @(negedge tck); #0.5 so[k] = tdo;
      end
      @(posedge tck); #1 sh = 0; upd = do_upd;
      @(posedge tck); #1 upd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge tck);
      #1;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         nfail++; nchk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [MB-1:0] prev, p;
      int base;
      #3 chk(tdo === 1'b0, "R1 tdo in reset", L'(tdo), '0);
      idle(3); trst_n = 1; idle(2);

      // R2/R3 echo through 16-bit path; R7 unknown code
      scan(1, 32, L'({16'h0BAD, 16'h5A5A}), 1);
      chk(so[15:0] == st(0, 0), "R1 reset status", L'(so[15:0]), L'(st(0, 0)));
      chk(so[31:16] == 16'h5A5A, "R2 16-bit echo", L'(so[31:16]), L'(16'h5A5A));
      chk(edge_ok, "R10 tdo stable at rising edge", L'(edge_ok), L'(1));
      scan(1, 16, L'(ARM), 1);
      chk(so[15:0] == st(0, 0), "R7 unknown code ignored", L'(so[15:0]), L'(st(0, 0)));
      chk(we_cnt == 0, "R7 no write", L'(we_cnt), '0);

      prev = '0;
      for (int it = 0; it < 4; it++) begin
         p = pat_of(it);
         base = we_cnt;
         scan(1, L, {COMMIT, p}, 1);
         chk(so[MB-1:0] == prev, "R3 capture of store", L'(so[MB-1:0]), L'(prev));
         chk(so[L-1:MB] == st(1, 0), "R3 write-enabled status", L'(so[L-1:MB]), L'(st(1, 0)));
         chk(edge_ok, "R10 tdo stable at rising edge", L'(edge_ok), L'(1));
         idle(NW + 4);
         chk(we_cnt == base + NW, "R4 write count", L'(we_cnt), L'(base + NW));
         chk(img == p && !addr_bad, "R4 written image", L'(img), L'(p));
         scan(1, 16, L'(CHECK), 1);
         chk(so[15:0] == st(0, 0), "R4 back to command-only", L'(so[15:0]), L'(st(0, 0)));
         scan(1, L, {CHECK, ~p}, 1);
         chk(so[MB-1:0] == p, "R6 verify readout", L'(so[MB-1:0]), L'(p));
         chk(so[L-1:MB] == st(2, 0), "R6 verify status", L'(so[L-1:MB]), L'(st(2, 0)));
         scan(1, L, {ARM, {MB{1'b0}}}, 1);
         chk(so[MB-1:0] == p && we_cnt == base + NW, "R6 store unchanged", L'(so[MB-1:0]), L'(p));
         prev = p;
      end

      // R5 abort in write-enabled mode
      base = we_cnt;
      scan(1, L, {16'h1111, ~prev}, 1);
      chk(so[L-1:MB] == st(1, 0), "R5 armed before abort", L'(so[L-1:MB]), L'(st(1, 0)));
      scan(1, 16, L'(CHECK), 1);
      chk(so[15:0] == st(0, 0), "R5 abort to command-only", L'(so[15:0]), L'(st(0, 0)));
      scan(1, L, '0, 1);
      chk(so[MB-1:0] == prev && we_cnt == base, "R5 no write on abort", L'(so[MB-1:0]), L'(prev));

      // R8 busy window
      scan(1, 16, L'(ARM), 1);
      p = pat_of(9);
      scan(1, L, {COMMIT, p}, 1);
      scan(1, 16, L'(ARM), 1);
      chk(so[15:0] == st(0, 1), "R8 busy status", L'(so[15:0]), L'(st(0, 1)));
      idle(40);
      scan(1, 16, '0, 1);
      chk(so[15:0] == st(0, 0), "R8 update ignored while busy", L'(so[15:0]), L'(st(0, 0)));
      chk(img == p, "R8 commit completed", L'(img), L'(p));

      // R9 test-logic-reset
      scan(1, 16, L'(ARM), 1);
      @(posedge tck); #1 tlr = 1;
      @(posedge tck); #1 tlr = 0;
      scan(1, 16, '0, 1);
      chk(so[15:0] == st(0, 0), "R9 tlr clears mode", L'(so[15:0]), L'(st(0, 0)));

      // R1 asynchronous reset mid-cycle
      scan(1, 16, L'(CHECK), 1);
      #0.7 trst_n = 0;
      #0.5 chk(tdo === 1'b0, "R1 tdo cleared", L'(tdo), '0);
      idle(2); trst_n = 1; idle(1);
      scan(1, 16, L'(CHECK), 1);
      chk(so[15:0] == st(0, 0), "R1 mode cleared", L'(so[15:0]), L'(st(0, 0)));
      scan(1, L, '0, 1);
      chk(so[MB-1:0] == '0, "R1 store cleared", L'(so[MB-1:0]), '0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule